// File: doc/BRIEF.md
# Peripheral Core State Sequencer

This block holds the operating state of a peripheral core and lets software move that core between reset, run and pause by writing a small register file. Every accepted change to the state field starts a settling window during which a valid flag reads low. Software is expected to poll that flag, both before it requests a change and after it has made one. A change requested while the flag is low is dropped, and a sticky error bit records the attempt.

A separate software-reset register returns all of the block's logic to its defaults. The block drives three enables that gate a downstream transfer engine: reset, run and pause. It also drives a flag that tells when the two maximum-transfer-count registers may be programmed. Those count registers take writes only while the state field reads reset. A transfer is therefore set up in reset, carried out in run, and ended by going back to reset.

All outputs are registered. Read data appears one clock after a read strobe.

Top module: `seq_core_state_ctrl`

## Requirements
- R1: The state field encodes reset as 0, run as 1 and pause as 3. While the valid flag is high, exactly one of eng_reset, eng_run and eng_pause is high, and it is the one that matches the state field.
- R2: A write to register 0 made while valid is high is accepted. The valid flag is then low for exactly SETTLE_CYC clock cycles, starting at the edge that takes the write, and high again after that.
- R3: An accepted write of code 2 to the state field is a clear request. It clears the sticky error bit, leaves the state field as it was, and starts the same settling window as any other accepted write.
- R4: A write to register 0 while valid is low is ignored. The state field and the settling window are unchanged, and the sticky error bit (bit 3 of register 0) is set.
- R5: Writing register 1 with bit 0 set is a software reset, and it is taken even during a settling window. It sets the state field to reset, clears both counts and the error bit, and holds valid low for HOLD_CYC cycles. A write to register 1 with bit 0 clear has no effect.
- R6: All three engine enables are low while valid is low.
- R7: Writes to the output-count register (2) and the input-count register (3) take effect only while the state field is reset; otherwise they are ignored. cnt_prog_ok is high exactly when the state field is reset.
- R8: A read returns, on the clock after bus_rd: for register 0, {error in bit 3, valid in bit 2, state in bits 1:0}; for register 1, zero; for registers 2 and 3, the output and input counts. bus_rdata holds its value when no read is made.
- R9: After rst the state field is reset, valid is high, the error bit and both counts are zero, eng_reset and cnt_prog_ok are high, and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| state_valid | output | 1 | High while the state is settled |
| eng_reset | output | 1 | Transfer engine held in reset |
| eng_run | output | 1 | Transfer engine allowed to run |
| eng_pause | output | 1 | Transfer engine paused |
| cnt_prog_ok | output | 1 | Count registers writable |
| max_out_cnt | output | CNT_W | Programmed output transfer count |
| max_in_cnt | output | CNT_W | Programmed input transfer count |

## Verification
A wrong settle counter shows at state_valid on the very first clock it is wrong: a window that runs one cycle long or short is caught at the edge where it should have ended. A wrong state field first shows at the engine enables, once valid rises. It also shows at once through cnt_prog_ok, and through count writes that are taken or refused against the rule. A lost or stuck error bit is visible only through a read of register 0, so reads are placed after each rejected write and after each clear request.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CST_RESET = 2'd0,
    CST_RUN   = 2'd1,
    CST_CLEAR = 2'd2,
    CST_PAUSE = 2'd3
  } core_st_t;

  localparam int REG_STATE = 0;
  localparam int REG_SWRST = 1;
  localparam int REG_OCNT  = 2;
  localparam int REG_ICNT  = 3;
  localparam int NUM_CNT   = 2;
endpackage

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int SETTLE_CYC = 4,
  parameter int HOLD_CYC   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_settle,
  input  logic start_hold,
  output logic stable_q,
  output logic stable_nxt
);
  localparam int MAXC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic [TW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start_hold)          cnt_nxt = TW'(HOLD_CYC);
    else if (start_settle)   cnt_nxt = TW'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_nxt = cnt_q - 1'b1;
  end

  assign stable_nxt = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      stable_q <= stable_nxt;
    end
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_state,
  input  logic [1:0] wr_code,
  input  logic       soft_rst,
  input  logic       stable,
  output core_st_t   state_q,
  output core_st_t   state_nxt,
  output logic       err_q,
  output logic       accept
);
  logic err_nxt;

  assign accept = wr_state && stable && !soft_rst;

  always_comb begin
    state_nxt = state_q;
    err_nxt   = err_q;
    if (soft_rst) begin
      state_nxt = CST_RESET;
      err_nxt   = 1'b0;
    end else if (wr_state) begin
      if (!stable) begin
        err_nxt = 1'b1;
      end else if (wr_code == CST_CLEAR) begin
        err_nxt = 1'b0;
      end else begin
        state_nxt = core_st_t'(wr_code);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CST_RESET;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      err_q   <= err_nxt;
    end
  end
endmodule

// File: rtl/seq_count_reg.sv
module seq_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             wr,
  input  logic             allow,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst)   cnt_q <= '0;
    else if (wr && allow)  cnt_q <= wdata;
  end
endmodule

// File: rtl/seq_core_state_ctrl.sv
module seq_core_state_ctrl
  import seq_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int HOLD_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              state_valid,
  output logic              eng_reset,
  output logic              eng_run,
  output logic              eng_pause,
  output logic              cnt_prog_ok,
  output logic [CNT_W-1:0]  max_out_cnt,
  output logic [CNT_W-1:0]  max_in_cnt
);
  localparam int STW = 4;

  logic wr_state, soft_rst, accept, stable_nxt;
  logic err_q;
  core_st_t state_q, state_nxt;
  logic [CNT_W-1:0] cnt_arr [NUM_CNT];
  logic [STW-1:0] status_word;
  logic unused_wdata;

  assign wr_state = bus_wr && (bus_addr == ADDR_W'(REG_STATE));
  assign soft_rst = bus_wr && (bus_addr == ADDR_W'(REG_SWRST)) && bus_wdata[0];
  assign unused_wdata = ^bus_wdata;

  seq_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start_settle (accept),
    .start_hold   (soft_rst),
    .stable_q     (state_valid),
    .stable_nxt   (stable_nxt)
  );

  seq_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_state  (wr_state),
    .wr_code   (bus_wdata[1:0]),
    .soft_rst  (soft_rst),
    .stable    (state_valid),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .err_q     (err_q),
    .accept    (accept)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    seq_count_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst),
      .wr       (bus_wr && (bus_addr == ADDR_W'(REG_OCNT + g))),
      .allow    (state_q == CST_RESET),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .cnt_q    (cnt_arr[g])
    );
  end

  assign max_out_cnt = cnt_arr[0];
  assign max_in_cnt  = cnt_arr[1];
  assign status_word = {err_q, state_valid, state_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_reset   <= 1'b1;
      eng_run     <= 1'b0;
      eng_pause   <= 1'b0;
      cnt_prog_ok <= 1'b1;
    end else begin
      eng_reset   <= stable_nxt && (state_nxt == CST_RESET);
      eng_run     <= stable_nxt && (state_nxt == CST_RUN);
      eng_pause   <= stable_nxt && (state_nxt == CST_PAUSE);
      cnt_prog_ok <= (state_nxt == CST_RESET);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(REG_STATE))      bus_rdata <= DATA_W'(status_word);
      else if (bus_addr == ADDR_W'(REG_OCNT))  bus_rdata <= DATA_W'(cnt_arr[0]);
      else if (bus_addr == ADDR_W'(REG_ICNT))  bus_rdata <= DATA_W'(cnt_arr[1]);
      else                                     bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/seq_core_state_chk.sv
module seq_core_state_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              state_valid,
  input logic              eng_reset,
  input logic              eng_run,
  input logic              eng_pause,
  input logic [CNT_W-1:0]  max_out_cnt,
  input logic [CNT_W-1:0]  max_in_cnt,
  input logic [1:0]        st_field,
  input logic              err_flag
);
  logic st_wr, sw_rst, ocnt_wr;
  assign st_wr   = bus_wr && (bus_addr == ADDR_W'(0));
  assign sw_rst  = bus_wr && (bus_addr == ADDR_W'(1)) && bus_wdata[0];
  assign ocnt_wr = bus_wr && (bus_addr == ADDR_W'(2));

  a_r1_one_enable_when_valid: assert property (@(posedge clk) disable iff (rst)
    state_valid |-> ($countones({eng_reset, eng_run, eng_pause}) == 1));

  a_r2_write_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (st_wr && state_valid) |=> !state_valid);

  a_r3_clear_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (st_wr && state_valid && bus_wdata[1:0] == 2'd2) |=> (!err_flag && $stable(st_field)));

  a_r4_busy_write_flags: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !state_valid) |=> (err_flag && $stable(st_field)));

  a_r5_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (max_out_cnt == '0 && max_in_cnt == '0 && st_field == 2'd0 && !state_valid));

  a_r6_quiet_while_settling: assert property (@(posedge clk) disable iff (rst)
    !state_valid |-> !(eng_reset || eng_run || eng_pause));

  a_r7_count_locked: assert property (@(posedge clk) disable iff (rst)
    (ocnt_wr && st_field != 2'd0) |=> $stable(max_out_cnt));
endmodule

bind seq_core_state_ctrl seq_core_state_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .state_valid (state_valid),
  .eng_reset   (eng_reset),
  .eng_run     (eng_run),
  .eng_pause   (eng_pause),
  .max_out_cnt (max_out_cnt),
  .max_in_cnt  (max_in_cnt),
  .st_field    (state_q),
  .err_flag    (err_q)
);

// File: tb/seq_core_state_ctrl_bench.sv
`timescale 1ns/1ps
module seq_core_state_ctrl_bench;
  localparam int ADDR_W = 2, DATA_W = 32, CNT_W = 16, SETTLE = 4, HOLD = 8;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic state_valid, eng_reset, eng_run, eng_pause, cnt_prog_ok;
  logic [CNT_W-1:0] max_out_cnt, max_in_cnt;

  int checks = 0, errors = 0, cyc = 0;
  int m_state = 0, m_busy = 0, m_err = 0, m_ocnt = 0, m_icnt = 0, m_rdata = 0;

  always #5 clk = ~clk;

  seq_core_state_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) u_seq_core_state_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .state_valid(state_valid),
    .eng_reset(eng_reset), .eng_run(eng_run), .eng_pause(eng_pause),
    .cnt_prog_ok(cnt_prog_ok), .max_out_cnt(max_out_cnt), .max_in_cnt(max_in_cnt));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    int pre_valid;
    cyc++;
    if (rst) begin
      m_state = 0; m_busy = 0; m_err = 0; m_ocnt = 0; m_icnt = 0; m_rdata = 0;
    end else begin
      pre_valid = (m_busy == 0) ? 1 : 0;
      if (bus_rd) begin
        case (int'(bus_addr))
          0: m_rdata = m_err * 8 + pre_valid * 4 + m_state;
          2: m_rdata = m_ocnt;
          3: m_rdata = m_icnt;
          default: m_rdata = 0;
        endcase
      end
      if (m_busy > 0) m_busy--;
      if (bus_wr) begin
        case (int'(bus_addr))
          0: begin
            if (pre_valid == 0) m_err = 1;
            else begin
              m_busy = SETTLE;
              if (bus_wdata[1:0] == 2'd2) m_err = 0;
              else m_state = int'(bus_wdata[1:0]);
            end
          end
          1: if (bus_wdata[0]) begin
            m_state = 0; m_err = 0; m_ocnt = 0; m_icnt = 0; m_busy = HOLD;
          end
          2: if (m_state == 0) m_ocnt = int'(bus_wdata[CNT_W-1:0]);
          default: if (m_state == 0) m_icnt = int'(bus_wdata[CNT_W-1:0]);
        endcase
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(state_valid == (m_busy == 0), "R2 valid window", int'(state_valid), int'(m_busy == 0));
      check({eng_reset, eng_run, eng_pause} ==
            {(m_busy == 0 && m_state == 0), (m_busy == 0 && m_state == 1), (m_busy == 0 && m_state == 3)},
            "R1/R6 engine enables", int'({eng_reset, eng_run, eng_pause}),
            int'({(m_busy == 0 && m_state == 0), (m_busy == 0 && m_state == 1), (m_busy == 0 && m_state == 3)}));
      check(cnt_prog_ok == (m_state == 0), "R7 cnt_prog_ok", int'(cnt_prog_ok), int'(m_state == 0));
      check(int'(max_out_cnt) == m_ocnt && int'(max_in_cnt) == m_icnt, "R7 counts",
            int'({max_out_cnt, max_in_cnt}), (m_ocnt << 16) | m_icnt);
      check(int'(bus_rdata) == m_rdata, "R8 read data", int'(bus_rdata), m_rdata);
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk); bus_rd = 0;
    check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    check(eng_reset && state_valid && cnt_prog_ok && !eng_run && !eng_pause,
          "R9 reset outputs", int'({eng_reset, state_valid, cnt_prog_ok}), 7);
    rd_chk(0, 4, "R9 status after reset");
    wr_reg(2, 32'h1234);
    wr_reg(3, 32'hBEEF);
    rd_chk(2, 32'h1234, "R7 out count in reset");
    rd_chk(3, 32'hBEEF, "R7 in count in reset");
    wr_reg(0, 1);
    wr_reg(0, 3);
    idle(6);
    rd_chk(0, 13, "R4 rejected write sets error, keeps run");
    check(eng_run, "R1 run enable", int'(eng_run), 1);
    wr_reg(2, 32'h5555);
    rd_chk(2, 32'h1234, "R7 count write ignored in run");
    wr_reg(0, 2);
    idle(6);
    rd_chk(0, 5, "R3 clear request");
    wr_reg(0, 3);
    idle(6);
    check(eng_pause && !eng_run, "R1 pause enable", int'({eng_pause, eng_run}), 2);
    rd_chk(0, 7, "R1 pause code");
    wr_reg(0, 0);
    idle(6);
    wr_reg(3, 32'h00AA);
    rd_chk(3, 32'h00AA, "R7 in count rewritten in reset");
    wr_reg(1, 0);
    rd_chk(2, 32'h1234, "R5 soft reset bit clear has no effect");
    wr_reg(0, 1);
    idle(6);
    wr_reg(1, 1);
    rd_chk(0, 0, "R5 soft reset holds valid low in reset");
    idle(10);
    rd_chk(2, 0, "R5 soft reset clears out count");
    rd_chk(3, 0, "R5 soft reset clears in count");
    wr_reg(0, 3);
    wr_reg(1, 1);
    idle(10);
    rd_chk(0, 4, "R5 soft reset during settling");
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule